// File: doc/BRIEF.md
# CRM Boost Switch Timing Controller

This block decides, cycle by cycle, when the power switch of a power-factor-correction boost stage is on. It runs the stage in critical conduction mode. A new conduction interval begins only after the inductor has been seen to run out of current. The interval ends when the inductor current reaches its programmed peak, or when an on-time ceiling is reached. Every time the block ends an interval itself, it issues a one-cycle completion pulse.

All inputs are synchronous to the 50 MHz clock and come from comparators outside the block. One input reports that the inductor is demagnetized, one that the current peak has been reached, and one that the boost output is overvoltage. All timing limits are given in nanoseconds and converted to clock-cycle counts.

Two timing limits cap the switching rate. A blanking interval after each turn-off hides demagnetization ringing, and a minimum rise-to-rise period limits the switching rate to 200 kHz. A restart timer forces a new interval when no valid demagnetization event arrives, so the stage cannot stall. An overvoltage flag or a low enable keeps the switch off.

Top module: `crm_boost_gate_ctl`

## Requirements
- R1: While reset is asserted, or in the cycle after `en_i` is sampled low, `gate_o` and `done_o` are 0. A low `en_i` also clears every timer. After `en_i` returns high, the earliest turn-on is therefore the 250th rising edge at which `en_i` is sampled high.
- R2: When `pk_i` is sampled 1 while the switch is on, `gate_o` is 0 from that edge on.
- R3: `gate_o` never stays high for more than 1000 consecutive cycles (20 us). Without `pk_i`, the on time is exactly 1000 cycles.
- R4: `zcd_i` is ignored at the first 100 rising edges after a turn-off (2 us). A demagnetization event seen only inside that window does not cause a turn-on.
- R5: Two successive rising edges of `gate_o` are at least 250 cycles apart (5 us, 200 kHz).
- R6: Turn-on happens at the first edge where all of the following hold: `zcd_i` is 1 outside blanking, at least 249 cycles have passed since the last turn-on, and `ovp_i` is 0. With `zcd_i` held high after a long on time, the switch is off for exactly 101 cycles.
- R7: A demagnetization event that arrives after blanking but before the minimum period has elapsed is remembered. The switch then turns on as soon as the period allows, even if `zcd_i` has since dropped.
- R8: If no accepted demagnetization event arrives, the switch turns on after 5000 cycles off (100 us).
- R9: While `ovp_i` is sampled 1, the switch does not turn on. Once it is sampled 0 with every other condition met, turn-on follows at that edge.
- R10: `done_o` is high for exactly one cycle: the first cycle with `gate_o` low after an interval ended by `pk_i` or by the on-time ceiling. A turn-off forced by `en_i` gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Run enable. Low forces the switch off and clears the timers |
| zcd_i | input | 1 | Inductor demagnetized (zero current), synchronous comparator |
| pk_i | input | 1 | Inductor current has reached the programmed peak |
| ovp_i | input | 1 | Boost output overvoltage; blocks turn-on |
| gate_o | output | 1 | Switch enable |
| done_o | output | 1 | One-cycle pulse after a normally ended on interval |

## Verification
Several directed patterns each isolate one timing limit.
- Demagnetization held high with no peak shows the on-time ceiling, and the 101-cycle off time shows blanking.
- Peak held high shows that the minimum period, rather than blanking, sets the 250-cycle rhythm.
- With demagnetization absent, only the 5000-cycle restart can start a cycle.
- A single demagnetization pulse is placed once before and once after the blanking edge. The early pulse must fall back to the restart timeout, and the late one must be latched until the period allows turn-on.
- Overvoltage held across a pending turn-on, and enable dropped during an on interval, separate the inhibit paths from the normal turn-off.

A seeded random phase then mixes all four inputs and compares both outputs every cycle with a cycle model written from the requirements.

// File: rtl/crmb_pkg.sv
package crmb_pkg;

  typedef enum logic {
    SW_OFF = 1'b0,
    SW_ON  = 1'b1
  } sw_state_e;

  // Convert a duration in ns into clock cycles for a clock given in MHz.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz) / 1000;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/crmb_sat_timer.sv
// Saturating up-counter with synchronous clear and explicit count enable.
module crmb_sat_timer #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CAP = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | (tick_i & (cnt_q != CAP));
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/crmb_demag_qual.sv
// Qualifies the demagnetization input against the blanking window and holds
// an accepted event until the next turn-on consumes it.
module crmb_demag_qual #(
  parameter int unsigned BLANK_CYC = 100,
  parameter int unsigned OFF_W     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             armed_i,
  input  logic [OFF_W-1:0] off_cnt_i,
  input  logic             zcd_i,
  output logic             zok_o
);

  localparam logic [OFF_W-1:0] BLANK_END = OFF_W'(BLANK_CYC);

  logic seen_q;
  logic seen_d;
  logic seen_en;
  logic fresh;

  always_comb begin
    fresh   = armed_i & zcd_i & (off_cnt_i >= BLANK_END);
    seen_en = clr_i | fresh;
    seen_d  = ~clr_i;
    zok_o   = seen_q | fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (seen_en) begin
      seen_q <= seen_d;
    end
  end

endmodule

// File: rtl/crm_boost_gate_ctl.sv
module crm_boost_gate_ctl
  import crmb_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 50,
  parameter int unsigned BLANK_NS      = 2000,
  parameter int unsigned MIN_PERIOD_NS = 5000,
  parameter int unsigned MAX_ON_NS     = 20000,
  parameter int unsigned RESTART_NS    = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic zcd_i,
  input  logic pk_i,
  input  logic ovp_i,
  output logic gate_o,
  output logic done_o
);

  localparam int unsigned BLANK_CYC   = ns_to_cyc(BLANK_NS, CLK_MHZ);
  localparam int unsigned MIN_PER_CYC = ns_to_cyc(MIN_PERIOD_NS, CLK_MHZ);
  localparam int unsigned MAX_ON_CYC  = ns_to_cyc(MAX_ON_NS, CLK_MHZ);
  localparam int unsigned RESTART_CYC = ns_to_cyc(RESTART_NS, CLK_MHZ);
  localparam int unsigned PER_LIM     = max_u(MIN_PER_CYC, MAX_ON_CYC);
  localparam int unsigned OFF_LIM     = max_u(RESTART_CYC, BLANK_CYC);
  localparam int unsigned PER_W       = $clog2(PER_LIM + 1);
  localparam int unsigned OFF_W       = $clog2(OFF_LIM + 1);

  localparam logic [PER_W-1:0] ON_LAST   = PER_W'(MAX_ON_CYC - 1);
  localparam logic [PER_W-1:0] PER_READY = PER_W'(MIN_PER_CYC - 1);
  localparam logic [OFF_W-1:0] RST_READY = OFF_W'(RESTART_CYC - 1);

  sw_state_e        state_q;
  sw_state_e        state_d;
  logic             done_q;
  logic             done_d;
  logic [PER_W-1:0] per_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic             zok;
  logic             turn_on;
  logic             turn_off;
  logic             end_on;
  logic             start_ok;

  // Cycles since the last turn-on: sets on-time ceiling and minimum period.
  crmb_sat_timer #(
    .LIMIT (PER_LIM),
    .W     (PER_W)
  ) u_per_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (~en_i | turn_on),
    .tick_i (en_i),
    .cnt_o  (per_cnt)
  );

  // Cycles since the last turn-off: sets blanking and restart timeout.
  crmb_sat_timer #(
    .LIMIT (OFF_LIM),
    .W     (OFF_W)
  ) u_off_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (~en_i | turn_off),
    .tick_i (en_i),
    .cnt_o  (off_cnt)
  );

  crmb_demag_qual #(
    .BLANK_CYC (BLANK_CYC),
    .OFF_W     (OFF_W)
  ) u_demag (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (~en_i | turn_on),
    .armed_i   (state_q == SW_OFF),
    .off_cnt_i (off_cnt),
    .zcd_i     (zcd_i),
    .zok_o     (zok)
  );

  always_comb begin
    end_on   = (state_q == SW_ON) & (pk_i | (per_cnt >= ON_LAST));
    start_ok = (state_q == SW_OFF) & ~ovp_i & (per_cnt >= PER_READY)
             & (zok | (off_cnt >= RST_READY));
    turn_on  = en_i & start_ok;
    turn_off = en_i & end_on;

    state_d = state_q;
    done_d  = 1'b0;
    if (!en_i) begin
      state_d = SW_OFF;
    end else if (turn_on) begin
      state_d = SW_ON;
    end else if (turn_off) begin
      state_d = SW_OFF;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_OFF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign gate_o = (state_q == SW_ON);
  assign done_o = done_q;

endmodule

// File: rtl/crmb_chk.sv
module crmb_chk
  import crmb_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 50,
  parameter int unsigned BLANK_NS      = 2000,
  parameter int unsigned MIN_PERIOD_NS = 5000,
  parameter int unsigned MAX_ON_NS     = 20000,
  parameter int unsigned RESTART_NS    = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic pk_i,
  input logic ovp_i,
  input logic gate_o,
  input logic done_o
);

  localparam int unsigned BLANK_CYC   = ns_to_cyc(BLANK_NS, CLK_MHZ);
  localparam int unsigned MIN_PER_CYC = ns_to_cyc(MIN_PERIOD_NS, CLK_MHZ);
  localparam int unsigned MAX_ON_CYC  = ns_to_cyc(MAX_ON_NS, CLK_MHZ);
  localparam int unsigned HI_W        = $clog2(MAX_ON_CYC + 1);
  localparam int unsigned LO_W        = $clog2(BLANK_CYC + 2);
  localparam int unsigned SR_W        = $clog2(MIN_PER_CYC + 1);

  logic [HI_W-1:0] hi_len;
  logic [LO_W-1:0] lo_len;
  logic [SR_W-1:0] since_rise;
  logic            gate_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len     <= '0;
      lo_len     <= '0;
      since_rise <= SR_W'(MIN_PER_CYC);
      gate_prev  <= 1'b0;
    end else begin
      gate_prev <= gate_o;
      if (!gate_o) begin
        hi_len <= '0;
      end else if (hi_len != HI_W'(MAX_ON_CYC)) begin
        hi_len <= hi_len + HI_W'(1);
      end
      if (gate_o) begin
        lo_len <= '0;
      end else if (lo_len != LO_W'(BLANK_CYC + 1)) begin
        lo_len <= lo_len + LO_W'(1);
      end
      if (gate_o && !gate_prev) begin
        since_rise <= SR_W'(1);
      end else if (since_rise != SR_W'(MIN_PER_CYC)) begin
        since_rise <= since_rise + SR_W'(1);
      end
    end
  end

  AST_DIS_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_o && !done_o)); // R1

  AST_PEAK_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && gate_o && pk_i) |=> !gate_o); // R2

  AST_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (hi_len < HI_W'(MAX_ON_CYC))); // R3

  AST_BLANK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (lo_len > LO_W'(BLANK_CYC))); // R4

  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (since_rise >= SR_W'(MIN_PER_CYC))); // R5

  AST_OVP_BLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_i && !gate_o) |=> !gate_o); // R9

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!gate_o && $past(gate_o))); // R10

  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && $past(en_i)) |-> done_o); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

endmodule

bind crm_boost_gate_ctl crmb_chk #(
  .CLK_MHZ       (CLK_MHZ),
  .BLANK_NS      (BLANK_NS),
  .MIN_PERIOD_NS (MIN_PERIOD_NS),
  .MAX_ON_NS     (MAX_ON_NS),
  .RESTART_NS    (RESTART_NS)
) u_crmb_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .pk_i   (pk_i),
  .ovp_i  (ovp_i),
  .gate_o (gate_o),
  .done_o (done_o)
);

// File: tb/test_crm_boost_gate_ctl.sv
`timescale 1ns/1ps
module test_crm_boost_gate_ctl;

  localparam int BLANK   = 2000 * 50 / 1000;
  localparam int MINPER  = 5000 * 50 / 1000;
  localparam int MAXON   = 20000 * 50 / 1000;
  localparam int RESTART = 100000 * 50 / 1000;

  logic clk;
  logic rst_n;
  logic en_i;
  logic zcd_i;
  logic pk_i;
  logic ovp_i;
  logic gate_o;
  logic done_o;

  crm_boost_gate_ctl i_crm_boost_gate_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .zcd_i  (zcd_i),
    .pk_i   (pk_i),
    .ovp_i  (ovp_i),
    .gate_o (gate_o),
    .done_o (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  // Cycle model built from the requirements.
  bit m_gate = 0;
  bit m_done = 0;
  int m_son  = 0;
  int m_soff = 0;
  bit m_dem  = 0;

  always @(posedge clk) begin
    bit zq;
    cyc++;
    if (!rst_n) begin
      m_gate = 0; m_done = 0; m_son = 0; m_soff = 0; m_dem = 0;
    end else if (!en_i) begin
      m_gate = 0; m_done = 0; m_son = 0; m_soff = 0; m_dem = 0;
    end else if (m_gate) begin
      if (pk_i || m_son >= MAXON - 1) begin
        m_gate = 0; m_done = 1; m_soff = 0;
      end else begin
        m_done = 0; m_soff++;
      end
      m_son++;
    end else begin
      m_done = 0;
      zq = m_dem || (zcd_i && m_soff >= BLANK);
      if (!ovp_i && m_son >= MINPER - 1 && (zq || m_soff >= RESTART - 1)) begin
        m_gate = 1; m_son = 0; m_dem = 0;
      end else begin
        m_dem = zq; m_son++;
      end
      m_soff++;
    end
  end

  // Edge bookkeeping and per-cycle model comparison, away from the active edge.
  bit g_prev = 0;
  int n_rise = 0;
  int n_fall = 0;
  int last_rise = 0;
  int prev_rise = 0;
  int last_fall = 0;
  int low_len = 0;
  int high_len = 0;
  int period = 0;
  bit fall_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(gate_o === m_gate, "R6 gate_o vs model", int'(gate_o), int'(m_gate));
      chk(done_o === m_done, "R10 done_o vs model", int'(done_o), int'(m_done));
    end
    if (gate_o && !g_prev) begin
      n_rise++; prev_rise = last_rise; last_rise = cyc;
      low_len = cyc - last_fall; period = cyc - prev_rise;
    end
    if (!gate_o && g_prev) begin
      n_fall++; last_fall = cyc; high_len = cyc - last_rise; fall_done = done_o;
    end
    g_prev = gate_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int c0;
    bit saw_high;
    void'($urandom(32'd48611));
    rst_n = 0; en_i = 0; zcd_i = 0; pk_i = 0; ovp_i = 0;
    repeat (3) @(negedge clk);
    chk(gate_o == 0 && done_o == 0, "R1 outputs in reset", int'({gate_o, done_o}), 0);
    rst_n = 1;
    @(negedge clk);

    // On-time ceiling, then blanking with demagnetization held high.
    en_i = 1; zcd_i = 1;
    wait (n_fall == 1);
    chk(high_len == MAXON, "R3 on time without peak", high_len, MAXON);
    chk(fall_done == 1, "R10 done at ceiling end", int'(fall_done), 1);
    wait (n_rise == 2);
    chk(low_len == BLANK + 1, "R4 R6 off time after blanking", low_len, BLANK + 1);

    // Peak held: one-cycle on, minimum period sets the rhythm.
    pk_i = 1;
    wait (n_rise == 3);
    chk(high_len == 1, "R2 peak ends on time", high_len, 1);
    chk(fall_done == 1, "R10 done at peak end", int'(fall_done), 1);
    chk(period == MINPER, "R5 minimum period", period, MINPER);

    // No demagnetization: restart timeout.
    zcd_i = 0;
    wait (n_rise == 4);
    chk(low_len == RESTART, "R8 restart after timeout", low_len, RESTART);

    // Event after blanking but before minimum period is latched.
    repeat (150) @(negedge clk);
    zcd_i = 1;
    @(negedge clk);
    zcd_i = 0;
    wait (n_rise == 5);
    chk(period == MINPER, "R7 latched event starts cycle", period, MINPER);

    // Event only inside blanking is ignored.
    repeat (50) @(negedge clk);
    zcd_i = 1;
    @(negedge clk);
    zcd_i = 0;
    wait (n_rise == 6);
    chk(low_len == RESTART, "R4 event in blanking ignored", low_len, RESTART);

    // Overvoltage inhibit.
    ovp_i = 1; zcd_i = 1;
    wait (n_fall == 6);
    saw_high = 0;
    repeat (2000) begin
      @(negedge clk);
      if (gate_o) saw_high = 1;
    end
    chk(saw_high == 0, "R9 no turn-on under overvoltage", int'(saw_high), 0);
    pk_i = 0; ovp_i = 0; c0 = cyc;
    wait (n_rise == 7);
    chk(last_rise - c0 == 1, "R9 turn-on after release", last_rise - c0, 1);

    // Enable low during on time.
    repeat (10) @(negedge clk);
    en_i = 0;
    @(negedge clk);
    chk(gate_o == 0, "R1 enable low forces off", int'(gate_o), 0);
    chk(done_o == 0, "R10 no done on forced off", int'(done_o), 0);
    repeat (5) @(negedge clk);
    en_i = 1; c0 = cyc;
    wait (n_rise == 8);
    chk(last_rise - c0 == MINPER, "R1 timers cleared by enable", last_rise - c0, MINPER);

    // Seeded random mix, checked against the model every cycle.
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      en_i  = ($urandom % 1500) != 0;
      if (($urandom % 700) == 0) ovp_i = ~ovp_i;
      pk_i  = ($urandom % 250) == 0;
      zcd_i = ($urandom % 30) == 0;
    end
    @(negedge clk);
    finish_run();
  end

endmodule